// File: doc/BRIEF.md
# Up/Down Event Tally with Preset Compare

This block is a single counting element modelled on the counter instruction of a programmable controller. Two level inputs, one for counting up and one for counting down, are watched for their inactive-to-active transitions. Each such transition moves a shared 16-bit two's-complement accumulator by one step. A preset register is loaded through its own write strobe. A done output reports whether the accumulator has reached or passed the preset in signed terms.

Overflow and underflow flags latch when a step carries the accumulator past the signed limits. In that case the accumulator wraps to the opposite limit. A typical use is a conveyor section with an infeed sensor on the up input and an outfeed sensor on the down input. The accumulator then holds the number of items inside the section. A second instance can take the done output of the first on its up input to form a cascade.

Top module: `updown_tally`

## Requirements
- R1: An inactive-to-active change on `cnt_up` raises the accumulator by one at the next clock edge. Keeping `cnt_up` high adds nothing more, and its falling edge has no effect.
- R2: An inactive-to-active change on `cnt_dn` lowers the accumulator by one at the next clock edge. Keeping `cnt_dn` high subtracts nothing more.
- R3: When both inputs change from low to high in the same cycle, the accumulator keeps its value.
- R4: `done` is 1 exactly when the signed accumulator is greater than or equal to the signed preset. It follows an accumulator change or a preset write with no extra cycle, so a down step below the preset clears it.
- R5: An up step taken at +32767 (16'h7FFF) leaves the accumulator at -32768 (16'h8000) and sets `ovf`. `ovf` then stays set until reset.
- R6: A down step taken at -32768 (16'h8000) leaves the accumulator at +32767 (16'h7FFF) and sets `unf`. `unf` then stays set until reset.
- R7: `up_stat` and `dn_stat` show the levels that `cnt_up` and `cnt_dn` had at the most recent clock edge.
- R8: Synchronous active-high `rst` has priority over counting. It clears the accumulator, `ovf` and `unf`, and leaves the preset unchanged.
- R9: With `preset_we` high at a clock edge, `preset_din` becomes the preset. With `preset_we` low, the preset keeps its value.
- R10: An input that is held high through reset and stays high afterwards produces no count once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | Up-count level input |
| cnt_dn | input | 1 | Down-count level input |
| preset_we | input | 1 | Preset write strobe |
| preset_din | input | 16 | Preset value to load (two's complement) |
| acc | output | 16 | Accumulator (two's complement) |
| preset | output | 16 | Current preset |
| up_stat | output | 1 | Registered level of `cnt_up` |
| dn_stat | output | 1 | Registered level of `cnt_dn` |
| done | output | 1 | Accumulator >= preset, signed |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The following results appear just after the first rising clock edge that sees the stimulus: the accumulator step from an edge, the status bits, the preset after a write and the overflow and underflow flags. `done` is derived combinationally from the accumulator and preset registers, so it moves in that same cycle and never a cycle later. The bench changes inputs at the falling edge and reads every output 1 ns after the next rising edge. Each vector is therefore checked against exactly one edge of latency.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int CNT_W = 16;
  localparam int NUM_IN = 2;
  localparam int UP_IDX = 0;
  localparam int DN_IDX = 1;

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_UP   = 2'b01,
    EV_DN   = 2'b10,
    EV_BOTH = 2'b11
  } step_ev_e;

  function automatic step_ev_e make_ev(input logic up, input logic dn);
    return step_ev_e'({dn, up});
  endfunction
endpackage

// File: rtl/tally_edge.sv
module tally_edge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] held
);
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic last_q;
      // Reset loads the live level, so a held input gives no edge after reset.
      always_ff @(posedge clk) begin
        last_q <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~last_q & ~rst;
      assign held[g] = last_q;

      assert_rise_once_R1: assert property (@(posedge clk) disable iff (rst)
        rise[g] |=> !rise[g])
        else $error("edge repeated on channel %0d", g);
    end
  endgenerate
endmodule

// File: rtl/tally_accum.sv
module tally_accum
  import tally_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  step_ev_e     ev,
  output logic [W-1:0] acc_q,
  output logic         ovf_q,
  output logic         unf_q
);
  localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (ev)
        EV_UP: begin
          if (acc_q == ACC_MAX) begin
            acc_q <= ACC_MIN;
            ovf_q <= 1'b1;
          end else begin
            acc_q <= acc_q + ONE;
          end
        end
        EV_DN: begin
          if (acc_q == ACC_MIN) begin
            acc_q <= ACC_MAX;
            unf_q <= 1'b1;
          end else begin
            acc_q <= acc_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assert_up_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_UP && acc_q != ACC_MAX) |=> acc_q == $past(acc_q) + ONE)
    else $error("up step wrong");
  assert_dn_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_DN && acc_q != ACC_MIN) |=> acc_q == $past(acc_q) - ONE)
    else $error("down step wrong");
  assert_both_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_BOTH || ev == EV_NONE) |=> $stable(acc_q))
    else $error("accumulator moved without single edge");
  assert_ovf_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_UP && acc_q == ACC_MAX) |=> (acc_q == ACC_MIN && ovf_q))
    else $error("overflow wrap wrong");
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q)
    else $error("overflow flag dropped");
  assert_unf_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_DN && acc_q == ACC_MIN) |=> (acc_q == ACC_MAX && unf_q))
    else $error("underflow wrap wrong");
  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> unf_q)
    else $error("underflow flag dropped");

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q && !rst) begin
      assert_rst_clear_R8: assert (acc_q == '0 && !ovf_q && !unf_q)
        else $error("reset did not clear state");
    end
  end
endmodule

// File: rtl/tally_preset.sv
module tally_preset #(
  parameter int          W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = INIT;
  always_ff @(posedge clk) begin
    if (we) q_r <= din;
  end
  assign q = q_r;
endmodule

// File: rtl/tally_cmp.sv
module tally_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         ge
);
  assign ge = $signed(lhs) >= $signed(rhs);
endmodule

// File: rtl/updown_tally.sv
module updown_tally
  import tally_pkg::*;
#(
  parameter int               WIDTH       = CNT_W,
  parameter logic [WIDTH-1:0] PRESET_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             preset_we,
  input  logic [WIDTH-1:0] preset_din,
  output logic [WIDTH-1:0] acc,
  output logic [WIDTH-1:0] preset,
  output logic             up_stat,
  output logic             dn_stat,
  output logic             done,
  output logic             ovf,
  output logic             unf
);
  logic [NUM_IN-1:0] lvl, rise, held;
  step_ev_e ev;

  assign lvl[UP_IDX] = cnt_up;
  assign lvl[DN_IDX] = cnt_dn;

  tally_edge #(.NCH(NUM_IN)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .held(held)
  );

  assign ev = make_ev(rise[UP_IDX], rise[DN_IDX]);

  tally_accum #(.W(WIDTH)) u_accum (
    .clk(clk), .rst(rst), .ev(ev), .acc_q(acc), .ovf_q(ovf), .unf_q(unf)
  );

  tally_preset #(.W(WIDTH), .INIT(PRESET_INIT)) u_preset (
    .clk(clk), .we(preset_we), .din(preset_din), .q(preset)
  );

  tally_cmp #(.W(WIDTH)) u_cmp (
    .lhs(acc), .rhs(preset), .ge(done)
  );

  assign up_stat = held[UP_IDX];
  assign dn_stat = held[DN_IDX];

  assert_preset_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !preset_we |=> $stable(preset))
    else $error("preset changed without write");
  assert_preset_load_R9: assert property (@(posedge clk) disable iff (rst)
    preset_we |=> preset == $past(preset_din))
    else $error("preset write lost");
endmodule

// File: tb/updown_tally_test.sv
`timescale 1ns/1ps
module updown_tally_test;
  localparam int W = 16;

  typedef struct packed {
    logic         up;
    logic         dn;
    logic         we;
    logic [W-1:0] pdin;
    logic [W-1:0] exp_acc;
    logic         exp_done;
  } vec_t;

  localparam int NV = 24;
  // Preset 3, then counting up, down and both; then preset -2 and counting down.
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 16'd3,      16'd0,      1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd0,      16'd1,      1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd0,      16'd1,      1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd1,      1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd0,      16'd2,      1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd2,      1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd0,      16'd3,      1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'd2,      1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd0,      16'd3,      1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd3,      1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd0,      16'd3,      1'b1},
    '{1'b0, 1'b0, 1'b1, 16'hFFFE,   16'd3,      1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'd2,      1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd2,      1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'd1,      1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd1,      1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'd0,      1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'd0,      1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'hFFFF,   1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'hFFFF,   1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'hFFFE,   1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd0,      16'hFFFE,   1'b1},
    '{1'b0, 1'b1, 1'b0, 16'd0,      16'hFFFD,   1'b0},
    '{1'b0, 1'b0, 1'b1, 16'hFFFD,   16'hFFFD,   1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_up = 1'b0, cnt_dn = 1'b0, preset_we = 1'b0;
  logic [W-1:0] preset_din = '0;
  logic [W-1:0] acc, preset;
  logic up_stat, dn_stat, done, ovf, unf;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  updown_tally uut (
    .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .preset_we(preset_we), .preset_din(preset_din),
    .acc(acc), .preset(preset), .up_stat(up_stat), .dn_stat(dn_stat),
    .done(done), .ovf(ovf), .unf(unf)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic tick(input logic up, input logic dn, input logic we,
                      input logic [W-1:0] pd, input logic r);
    @(negedge clk);
    cnt_up = up; cnt_dn = dn; preset_we = we; preset_din = pd; rst = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tick(0, 0, 1, 16'd5, 1);
    tick(0, 0, 0, 16'd0, 1);
    tick(0, 0, 0, 16'd0, 0);
    check("R8", "acc after reset", acc, 0);
    check("R8", "ovf after reset", ovf, 0);
    check("R8", "unf after reset", unf, 0);
    check("R9", "preset loaded", preset, 5);
    check("R4", "done 0<5", done, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i].up, VEC[i].dn, VEC[i].we, VEC[i].pdin, 0);
      check("R1", $sformatf("vec %0d acc", i), acc, VEC[i].exp_acc);
      check("R4", $sformatf("vec %0d done", i), done, VEC[i].exp_done);
      check("R7", $sformatf("vec %0d up_stat", i), up_stat, VEC[i].up);
      check("R7", $sformatf("vec %0d dn_stat", i), dn_stat, VEC[i].dn);
      if (VEC[i].we) check("R9", $sformatf("vec %0d preset", i), preset, VEC[i].pdin);
      check("R5", $sformatf("vec %0d ovf", i), ovf, 0);
    end
    // Preset unchanged without strobe, even with data driven
    tick(0, 0, 0, 16'h1234, 0);
    check("R9", "preset without strobe", preset, 16'hFFFD);

    // Reset keeps preset; done reflects 0 >= -3
    tick(0, 0, 0, 16'd0, 1);
    tick(0, 0, 0, 16'd0, 0);
    check("R8", "acc cleared", acc, 0);
    check("R8", "preset retained", preset, 16'hFFFD);
    check("R4", "done after reset", done, 1);

    // Overflow path
    for (int k = 0; k < 32767; k++) begin
      tick(1, 0, 0, 16'd0, 0);
      tick(0, 0, 0, 16'd0, 0);
    end
    check("R5", "acc at max", acc, 16'h7FFF);
    check("R5", "ovf before wrap", ovf, 0);
    tick(1, 0, 0, 16'd0, 0);
    check("R5", "acc wrapped to min", acc, 16'h8000);
    check("R5", "ovf set", ovf, 1);
    check("R4", "done at min vs -3", done, 0);
    tick(0, 0, 0, 16'd0, 0);
    tick(0, 1, 0, 16'd0, 0);
    check("R6", "acc wrapped to max", acc, 16'h7FFF);
    check("R6", "unf set", unf, 1);
    check("R5", "ovf sticky", ovf, 1);
    tick(0, 0, 0, 16'd0, 0);
    tick(0, 1, 0, 16'd0, 0);
    check("R2", "step down from max", acc, 16'h7FFE);
    check("R6", "unf sticky", unf, 1);
    tick(0, 0, 0, 16'd0, 0);
    tick(1, 1, 0, 16'd0, 0);
    check("R3", "both edges no change", acc, 16'h7FFE);

    // Reset priority over an up edge, input held through reset
    tick(0, 0, 0, 16'd0, 0);
    tick(1, 0, 0, 16'd0, 1);
    check("R8", "reset beats edge", acc, 0);
    check("R8", "ovf cleared", ovf, 0);
    check("R8", "unf cleared", unf, 0);
    tick(1, 0, 0, 16'd0, 0);
    tick(1, 0, 0, 16'd0, 0);
    check("R10", "held input after reset", acc, 0);
    check("R7", "up_stat held", up_stat, 1);
    tick(0, 0, 0, 16'd0, 0);
    tick(1, 0, 0, 16'd0, 0);
    check("R1", "fresh edge after reset", acc, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule